// File: doc/BRIEF.md
# Memory-Mapped 24-Bit Down-Counting Tick Timer

This block is a small countdown timer that sits on a simple synchronous register bus. Software stores a reload value and picks what drives the count: every core clock cycle, or only the cycles on which an external reference tick is high. It then sets the enable bit. While enabled, the counter moves one step per count event. From zero it loads the reload value. From any other value it decrements by one.

When the counter steps from one to zero, a sticky count flag sets. If the interrupt enable bit is also set, a one-cycle interrupt request pulse is issued. Software can leave interrupts off and poll the current value as a free-running timebase. A read of the control word returns the count flag and clears it. A write of any data to the current-value word forces the counter to zero and also drops the flag. A read-only calibration word returns a constant chosen at build time.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value words read zero and `irq` is low. Register selection uses byte address bits [3:2]: 0x0 is control, 0x4 is reload, 0x8 is current value and 0xC is calibration.
- R2: The reload and current-value words hold 24 bits, and their bits [31:24] read zero. An access whose address bits [1:0] are not zero changes nothing and reads zero. Control bits other than 0, 1, 2 and 16 read zero.
- R3: With control bit 0 (enable) and bit 2 (source) set, the counter steps on every clock cycle. A step from zero loads the reload value, and a step from a non-zero value subtracts one.
- R4: With control bit 2 clear, the counter steps only at clock edges where `ref_tick` is high.
- R5: A write of any data to the current-value word sets the counter to zero at that clock edge. The written data is never loaded.
- R6: Control bit 16 (count flag) sets when the counter steps from 1 to 0. A read of the control word returns the flag and clears it at that edge. If a set and a read-clear fall on the same edge, the set wins.
- R7: When control bit 1 is set, `irq` is high for exactly the one cycle that follows a 1-to-0 step. When bit 1 is clear, `irq` stays low.
- R8: The calibration word always reads the `CAL_VALUE` parameter, and writes to it have no effect.
- R9: With a reload value of zero, the enabled counter stays at zero and the count flag never sets.
- R10: With control bit 0 clear, the counter holds its value.
- R11: A write to the current-value word at the same edge as a 1-to-0 step wins. The counter becomes zero, the flag is cleared, and `irq` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference count tick, sampled at clock edges |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the count flag on a control read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Three pairs of events can land on the same clock edge: a flag-setting 1-to-0 step and a clearing control read, a 1-to-0 step and a current-value write, and a step and a control write. The bench sets the reload to 2 with the core clock as source and counts edges from the enabling write. This lets it place a control read, or a current-value write, exactly on the edge where the counter leaves 1. It then judges the outcome from later register reads and the `irq` pin: the flag must survive the simultaneous read, and the write must suppress both the flag and the pulse.

// File: rtl/tick_timer_pkg.sv
// Package: shared register selectors, control bit positions and sizes
// for the tick timer. Assumes a 32-bit data bus and a 4-bit byte address.
package tick_timer_pkg;

    localparam int ADDR_W = 4;

    // Word selector taken from byte address bits [3:2]
    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    localparam int BIT_ENABLE = 0;
    localparam int BIT_IRQ_EN = 1;
    localparam int BIT_SOURCE = 2;
    localparam int BIT_FLAG   = 16;

    // Software-writable control fields
    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/tick_timer_decode.sv
// Module: tick_timer_decode
// Turns a bus access into per-register strobes and a word selector.
// Assumes word-aligned accesses; an access with nonzero address bits [1:0]
// hits no register.
module tick_timer_decode
    import tick_timer_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output reg_sel_e          sel,
    output logic              aligned,
    output logic              wr_ctrl,
    output logic              wr_reload,
    output logic              wr_current,
    output logic              rd_ctrl
);

    // Select the word and check alignment
    always_comb begin
        sel     = reg_sel_e'(bus_addr[3:2]);
        aligned = (bus_addr[1:0] == 2'b00);
    end

    // Produce one-hot access strobes
    always_comb begin
        wr_ctrl    = bus_wr && aligned && (sel == SEL_CTRL);
        wr_reload  = bus_wr && aligned && (sel == SEL_RELOAD);
        wr_current = bus_wr && aligned && (sel == SEL_CURRENT);
        rd_ctrl    = bus_rd && aligned && (sel == SEL_CTRL);
    end

endmodule

// File: rtl/tick_timer_stepgen.sv
// Module: tick_timer_stepgen
// Chooses the count source. It emits one step strobe per core cycle, or one
// per cycle with ref_tick high. Assumes ref_tick is already synchronous to clk.
module tick_timer_stepgen (
    input  logic enable,
    input  logic src_core,
    input  logic ref_tick,
    output logic step
);

    // Gate the selected source with the enable bit
    always_comb begin
        step = enable && (src_core ? 1'b1 : ref_tick);
    end

endmodule

// File: rtl/tick_timer_counter.sv
// Module: tick_timer_counter
// Holds the down counter. It reloads from zero, decrements otherwise, reports
// the 1-to-0 step and registers the interrupt pulse. A clear request
// overrides counting and suppresses the 1-to-0 event.
module tick_timer_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] value,
    output logic             wrap,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    // Detect the 1-to-0 step that is not overridden by a clear
    always_comb begin
        wrap = step && !clear && (value == ONE);
    end

    // Count, reload or clear the current value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= ZERO;
        end else if (clear) begin
            value <= ZERO;
        end else if (step) begin
            value <= (value == ZERO) ? reload : value - ONE;
        end
    end

    // Register a one-cycle interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap && irq_en;
        end
    end

endmodule

// File: rtl/tick_timer_regs.sv
// Module: tick_timer_regs
// Stores the control and reload words and the sticky count flag, and drives
// the read data multiplexer. Assumes one access per cycle. When a flag set
// and a clear coincide, the set takes priority.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CAL_VALUE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  reg_sel_e          sel,
    input  logic              aligned,
    input  logic              wr_ctrl,
    input  logic              wr_reload,
    input  logic              wr_current,
    input  logic              rd_ctrl,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  cur_value,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              flag,
    output logic [DATA_W-1:0] rdata
);

    // Capture the control fields on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.enable   <= wdata[BIT_ENABLE];
            ctrl.irq_en   <= wdata[BIT_IRQ_EN];
            ctrl.src_core <= wdata[BIT_SOURCE];
        end
    end

    // Capture the low counter-width bits on a reload write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (wr_reload) begin
            reload <= wdata[CNT_W-1:0];
        end
    end

    // Keep the sticky flag: a 1-to-0 step sets it, a read or clear drops it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (rd_ctrl || wr_current) begin
            flag <= 1'b0;
        end
    end

    // Build the read word for the selected register
    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_CTRL: begin
                    rdata[BIT_ENABLE] = ctrl.enable;
                    rdata[BIT_IRQ_EN] = ctrl.irq_en;
                    rdata[BIT_SOURCE] = ctrl.src_core;
                    rdata[BIT_FLAG]   = flag;
                end
                SEL_RELOAD:  rdata = DATA_W'(reload);
                SEL_CURRENT: rdata = DATA_W'(cur_value);
                SEL_CALIB:   rdata = DATA_W'(CAL_VALUE);
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer
// Top level of the memory-mapped down-counting tick timer. It wires the
// decoder, register file, step generator and counter together. Assumes a
// single synchronous bus master and a ref_tick synchronous to clk.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CAL_VALUE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    reg_sel_e         sel;
    logic             aligned;
    logic             wr_ctrl;
    logic             wr_reload;
    logic             wr_current;
    logic             rd_ctrl;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_val;
    logic             flag_q;
    logic             cnt_step;
    logic             wrap;

    tick_timer_decode u_decode (
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .sel        (sel),
        .aligned    (aligned),
        .wr_ctrl    (wr_ctrl),
        .wr_reload  (wr_reload),
        .wr_current (wr_current),
        .rd_ctrl    (rd_ctrl)
    );

    tick_timer_regs #(
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .CAL_VALUE (CAL_VALUE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata      (bus_wdata),
        .sel        (sel),
        .aligned    (aligned),
        .wr_ctrl    (wr_ctrl),
        .wr_reload  (wr_reload),
        .wr_current (wr_current),
        .rd_ctrl    (rd_ctrl),
        .wrap       (wrap),
        .cur_value  (cur_val),
        .ctrl       (ctrl),
        .reload     (reload_q),
        .flag       (flag_q),
        .rdata      (bus_rdata)
    );

    tick_timer_stepgen u_stepgen (
        .enable   (ctrl.enable),
        .src_core (ctrl.src_core),
        .ref_tick (ref_tick),
        .step     (cnt_step)
    );

    tick_timer_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (cnt_step),
        .clear  (wr_current),
        .irq_en (ctrl.irq_en),
        .reload (reload_q),
        .value  (cur_val),
        .wrap   (wrap),
        .irq    (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Module: tick_timer_chk
// Property checker bound into tick_timer. It observes ports and internal
// state and changes nothing.
module tick_timer_chk #(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              en,
    input logic              step,
    input logic [CNT_W-1:0]  cur_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic              flag_q
);

    logic cur_write;

    // Recognise an aligned write to the current-value word
    always_comb begin
        cur_write = bus_wr && (bus_addr == ADDR_W'(8));
    end

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8)) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cur_write && cur_q != '0) |=> (cur_q == $past(cur_q) - CNT_W'(1)));

    assert_reload_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cur_write && cur_q == '0) |=> (cur_q == $past(reload_q)));

    assert_cur_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_write |=> (cur_q == '0 && !flag_q));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cur_write && cur_q == CNT_W'(1)) |=> flag_q);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q && cur_q == '0));

    assert_zero_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == '0 && cur_q == '0) |=> (cur_q == '0 && !irq));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cur_write) |=> $stable(cur_q));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_write && step && cur_q == CNT_W'(1)) |=> (!irq && !flag_q));

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (tick_timer_pkg::ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .en        (ctrl.enable),
    .step      (cnt_step),
    .cur_q     (cur_val),
    .reload_q  (reload_q),
    .flag_q    (flag_q)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] CAL        = 32'h4000_1234;
    localparam logic [3:0]  A_CTRL     = 4'h0;
    localparam logic [3:0]  A_RELOAD   = 4'h4;
    localparam logic [3:0]  A_CUR      = 4'h8;
    localparam logic [3:0]  A_CAL      = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tick_timer #(.CNT_W(24), .DATA_W(32), .CAL_VALUE(CAL)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bus write: effective at the next rising edge, returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Bus read with side effect: data captured before the edge
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Side-effect-free look at the read data
    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Expected counter value after n core-clock steps from zero with reload r
    function automatic logic [31:0] exp_cur(input int r, input int n);
        if (n == 0 || r == 0) return 32'd0;
        return 32'(r - ((n - 1) % (r + 1)));
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(A_CTRL, d);   check("R1 ctrl", d, 32'h0);
        peek(A_RELOAD, d); check("R1 reload", d, 32'h0);
        peek(A_CUR, d);    check("R1 current", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R8: calibration is constant and ignores writes
        peek(A_CAL, d); check("R8 calib", d, CAL);
        wr(A_CAL, ~CAL);
        peek(A_CAL, d); check("R8 calib after write", d, CAL);

        // R2: masking and misaligned accesses
        wr(A_RELOAD, 32'hFFFF_FFFF);
        peek(A_RELOAD, d); check("R2 reload upper zero", d, 32'h00FF_FFFF);
        peek(4'h5, d); check("R2 misaligned read", d, 32'h0);
        wr(4'h6, 32'h5);
        peek(A_RELOAD, d); check("R2 misaligned write ignored", d, 32'h00FF_FFFF);
        wr(A_CTRL, 32'hFFFF_FFF8);
        peek(A_CTRL, d); check("R2 ctrl unused bits", d, 32'h0);

        // R3, R7, R9, R10, R6: sweep reload values with the core clock source
        for (int r = 0; r <= 6; r++) begin
            int kmax;
            int ie;
            logic exp_irq;
            kmax = 3 * (r + 1) + 2;
            ie = r % 2;
            wr(A_CTRL, 32'h0);
            wr(A_CUR, 32'h0);
            wr(A_RELOAD, 32'(r));
            wr(A_CTRL, 32'h5 | 32'(ie << 1));
            for (int k = 1; k <= kmax; k++) begin
                @(negedge clk);
                peek(A_CUR, d);
                check(r == 0 ? "R9 zero reload holds" : "R3 core count", d, exp_cur(r, k));
                exp_irq = (ie == 1) && (r > 0) && (((k - 1) % (r + 1)) == r);
                check("R7 irq pulse", {31'b0, irq}, {31'b0, exp_irq});
            end
            wr(A_CTRL, 32'h0);
            rd(A_CTRL, d);
            check(r == 0 ? "R9 flag never sets" : "R6 flag set", {31'b0, d[16]}, {31'b0, (r > 0)});
            rd(A_CTRL, d);
            check("R6 flag cleared by read", {31'b0, d[16]}, 32'h0);
            repeat (4) @(negedge clk);
            peek(A_CUR, d);
            check("R10 hold when disabled", d, exp_cur(r, kmax + 1));
        end

        // R4: reference tick source, ticks on every third cycle
        wr(A_CTRL, 32'h0);
        wr(A_CUR, 32'h0);
        wr(A_RELOAD, 32'd3);
        wr(A_CTRL, 32'h1);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            ref_tick = (i % 3 == 0);
            @(negedge clk);
            if (i % 3 == 0) n++;
            peek(A_CUR, d);
            check("R4 reference count", d, exp_cur(3, n));
        end
        ref_tick = 1'b0;

        // R5: current-value write zeroes counter, data not loaded
        wr(A_CTRL, 32'h0);
        wr(A_CUR, 32'h0);
        wr(A_RELOAD, 32'd100);
        wr(A_CTRL, 32'h5);
        repeat (10) @(negedge clk);
        peek(A_CUR, d); check("R5 pre-write count", d, 32'd91);
        wr(A_CUR, 32'h00AB_CDEF);
        peek(A_CUR, d); check("R5 write zeroes", d, 32'h0);

        // R5: current-value write clears the flag
        wr(A_RELOAD, 32'd1);
        repeat (4) @(negedge clk);
        wr(A_CTRL, 32'h0);
        wr(A_CUR, 32'h1234);
        rd(A_CTRL, d); check("R5 flag cleared by write", {31'b0, d[16]}, 32'h0);

        // R6: flag set and read-clear on the same edge, set wins
        wr(A_CUR, 32'h0);
        wr(A_RELOAD, 32'd2);
        wr(A_CTRL, 32'h5);
        @(negedge clk);
        @(negedge clk);
        rd(A_CTRL, d); check("R6 read before set", {31'b0, d[16]}, 32'h0);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d); check("R6 set wins over read", {31'b0, d[16]}, 32'h1);
        rd(A_CTRL, d); check("R6 cleared after read", {31'b0, d[16]}, 32'h0);

        // R11: current-value write on the 1-to-0 edge wins
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h7);
        @(negedge clk);
        @(negedge clk);
        peek(A_CUR, d); check("R11 at one", d, 32'h1);
        wr(A_CUR, 32'h00FF_FFFF);
        peek(A_CUR, d); check("R11 counter zero", d, 32'h0);
        check("R11 no irq", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d); check("R11 no flag", {31'b0, d[16]}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule